// File: doc/BRIEF.md
# Late-Write Flow-Through Burst SRAM

This block is a small synchronous SRAM core and the controller that runs it. On every rising clock edge it samples a chip-select, two select inputs whose active levels are set by parameters, a burst-continue input, a write strobe and one active-low write enable per 9-bit lane. From these it decodes one of five operations: bank deselect, deselect, write, read and burst continue. A write takes its data one edge after the command (late write). A read puts the addressed word on the output side of the data bus in the cycle right after the command edge, with no output register (flow-through). A 2-bit burst counter steps the address on continue operations and wraps inside the aligned group of four words. A separate enable for the echo clocks drops only after a bank deselect, and only one clock later.

The data bus is split into an input word, an output word and an output-enable, which together form the bidirectional pad. The data path is a fixed-timing interface with no valid/ready handshake. The array accepts every write beat on the edge that follows its command, and every read word is present for exactly one cycle. No side can apply back-pressure, so the surrounding logic must present write data on the required edge.

Top module: `sram_lw_top`

## Requirements
- R1: The composite select is true only when `sel_a == POL_A` and `sel_b == POL_B`. A non-continue edge with the select false is a bank deselect: `dq_oe` is low in the next cycle and nothing is stored.
- R2: A non-continue edge with the select true and `ce_n` high is a deselect. `dq_oe` stays low, nothing is stored and `echo_oe` is not dropped.
- R3: A non-continue edge with select true, `ce_n` low and `wr_n` low starts a write and loads `addr` as the burst base. The data for that beat is taken from `dq_i` on the next edge. Lane i (bits 9i+8..9i) is stored only if bit i of `lane_wr_n` was low at the command edge.
- R4: A write or write-continue beat with every bit of `lane_wr_n` high stores nothing.
- R5: A non-continue edge with select true, `ce_n` low and `wr_n` high starts a read. In the cycle after that edge `dq_oe` is high and `dq_o` holds the addressed word.
- R6: A continue edge (`burst_cont` high) after a read or write repeats that operation at the next address. The effective address keeps the base's upper bits, and its two low bits are the base's low bits plus the beat count, modulo 4.
- R7: The fourth continue after one base address wraps back to the base address.
- R8: A continue edge after a deselect or bank deselect keeps that deselect state. The bus is not driven and nothing is stored, whatever `wr_n` and `lane_wr_n` are.
- R9: `echo_oe` falls at the second edge after a bank deselect is sampled. It stays low while bank deselect continues. It rises again at the second edge after the first edge of any other operation.
- R10: A read issued on the edge that takes a write's data returns the newly written lanes.
- R11: During and right after reset, `dq_oe` is low, `echo_oe` is high and the controller is in the deselect state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Active-low chip select |
| sel_a | input | 1 | Select input, active level POL_A |
| sel_b | input | 1 | Select input, active level POL_B |
| burst_cont | input | 1 | High: continue the current operation |
| wr_n | input | 1 | Low: write, high: read |
| lane_wr_n | input | LANES | Active-low per-lane write enables |
| addr | input | ADDR_W | External word address |
| dq_i | input | DATA_W | Write data, sampled one edge after its command |
| dq_o | output | DATA_W | Read data, valid while dq_oe is high |
| dq_oe | output | 1 | Data bus output enable |
| echo_oe | output | 1 | Echo clock output enable |

## Verification
The bench targets the timing edges of the block. It checks write data taken one edge late, so a design that samples data with the command stores the wrong word. It reads on the very edge that completes a write, so a design with a stale read path returns the old value. It reads back lanes with mixed enables and all-disabled beats, which catches lane masks that are inverted or ignored. It runs bursts that start mid-group and continue past four beats, where a full-width adder would carry into the upper address bits or fail to wrap. It also times `echo_oe` edge by edge around bank deselect, plain deselect and continues after deselect, where a design off by one cycle, or one that drops the echo on a plain deselect, shows up at once.

// File: rtl/sram_lw_pkg.sv
package sram_lw_pkg;
  localparam int LANE_W = 9;
  localparam int BEAT_W = 2;

  typedef enum logic [1:0] {
    OP_BANK_OFF = 2'd0,
    OP_IDLE     = 2'd1,
    OP_READ     = 2'd2,
    OP_WRITE    = 2'd3
  } op_e;
endpackage

// File: rtl/sram_lw_decode.sv
module sram_lw_decode
  import sram_lw_pkg::*;
#(
  parameter bit POL_A = 1'b1,
  parameter bit POL_B = 1'b0
) (
  input  logic ce_n,
  input  logic sel_a,
  input  logic sel_b,
  input  logic burst_cont,
  input  logic wr_n,
  input  op_e  cur_op,
  output op_e  nxt_op,
  output logic load,
  output logic step
);
  logic sel_ok;

  always_comb begin
    sel_ok = (sel_a == POL_A) && (sel_b == POL_B);
    nxt_op = cur_op;
    load   = 1'b0;
    step   = 1'b0;
    if (!burst_cont) begin
      if (!sel_ok) begin
        nxt_op = OP_BANK_OFF;
      end else if (ce_n) begin
        nxt_op = OP_IDLE;
      end else begin
        load   = 1'b1;
        nxt_op = wr_n ? OP_READ : OP_WRITE;
      end
    end else if (cur_op == OP_READ || cur_op == OP_WRITE) begin
      step = 1'b1;
    end
  end
endmodule

// File: rtl/sram_lw_burst.sv
module sram_lw_burst
  import sram_lw_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] eff_addr
);
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] cnt_q;
  logic [BEAT_W-1:0] low_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= addr;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign low_sum  = base_q[BEAT_W-1:0] + cnt_q;
  assign eff_addr = {base_q[ADDR_W-1:BEAT_W], low_sum};
endmodule

// File: rtl/sram_lw_array.sv
module sram_lw_array
  import sram_lw_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6,
  parameter int LANES  = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [LANES-1:0]  lane_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && lane_en[g]) begin
        mem[addr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[addr];
  end
endmodule

// File: rtl/sram_lw_echo.sv
module sram_lw_echo
  import sram_lw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  op_e  cur_op,
  output logic echo_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      echo_oe <= 1'b1;
    end else begin
      echo_oe <= (cur_op != OP_BANK_OFF);
    end
  end
endmodule

// File: rtl/sram_lw_top.sv
module sram_lw_top
  import sram_lw_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6,
  parameter bit POL_A  = 1'b1,
  parameter bit POL_B  = 1'b0,
  parameter int LANES  = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              sel_a,
  input  logic              sel_b,
  input  logic              burst_cont,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              echo_oe
);
  op_e               op_q;
  op_e               nxt_op;
  logic              load;
  logic              step;
  logic [ADDR_W-1:0] eff_addr;
  logic [LANES-1:0]  lane_n_q;
  logic [DATA_W-1:0] rd_word;
  logic              wr_en;

  sram_lw_decode #(
    .POL_A(POL_A),
    .POL_B(POL_B)
  ) i_decode (
    .ce_n      (ce_n),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .burst_cont(burst_cont),
    .wr_n      (wr_n),
    .cur_op    (op_q),
    .nxt_op    (nxt_op),
    .load      (load),
    .step      (step)
  );

  sram_lw_burst #(
    .ADDR_W(ADDR_W)
  ) i_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .addr    (addr),
    .eff_addr(eff_addr)
  );

  // Command state and the lane mask that belongs to the beat now in flight.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_IDLE;
      lane_n_q <= '1;
    end else begin
      op_q     <= nxt_op;
      lane_n_q <= lane_wr_n;
    end
  end

  // The beat registered last edge is a write: its data arrives on this edge.
  assign wr_en = (op_q == OP_WRITE);

  sram_lw_array #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .LANES (LANES)
  ) i_array (
    .clk    (clk),
    .wr_en  (wr_en),
    .lane_en(~lane_n_q),
    .addr   (eff_addr),
    .wdata  (dq_i),
    .rdata  (rd_word)
  );

  assign dq_oe = (op_q == OP_READ);
  assign dq_o  = dq_oe ? rd_word : '0;

  sram_lw_echo i_echo (
    .clk    (clk),
    .rst_n  (rst_n),
    .cur_op (op_q),
    .echo_oe(echo_oe)
  );
endmodule

// File: rtl/sram_lw_checker.sv
module sram_lw_checker #(
  parameter int ADDR_W = 6,
  parameter bit POL_A  = 1'b1,
  parameter bit POL_B  = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              sel_a,
  input logic              sel_b,
  input logic              burst_cont,
  input logic              wr_n,
  input logic [ADDR_W-1:0] addr,
  input logic              dq_oe,
  input logic              echo_oe,
  input logic [ADDR_W-1:0] eff_addr,
  input logic              step
);
  logic sel_ok, bank_cmd, desel_cmd, rd_cmd, wr_cmd;

  assign sel_ok    = (sel_a == POL_A) && (sel_b == POL_B);
  assign bank_cmd  = !burst_cont && !sel_ok;
  assign desel_cmd = !burst_cont && sel_ok && ce_n;
  assign rd_cmd    = !burst_cont && sel_ok && !ce_n && wr_n;
  assign wr_cmd    = !burst_cont && sel_ok && !ce_n && !wr_n;

  assert_bank_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bank_cmd |=> !dq_oe);

  assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    desel_cmd |=> !dq_oe);

  assert_write_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> !dq_oe);

  assert_read_flow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> dq_oe);

  assert_base_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd || wr_cmd) |=> (eff_addr == $past(addr)));

  assert_beat_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (eff_addr[1:0] == $past(eff_addr[1:0]) + 2'd1)
          && (eff_addr[ADDR_W-1:2] == $past(eff_addr[ADDR_W-1:2])));

  assert_echo_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bank_cmd |=> ##1 !echo_oe);
endmodule

bind sram_lw_top sram_lw_checker #(
  .ADDR_W(ADDR_W),
  .POL_A (POL_A),
  .POL_B (POL_B)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_n      (ce_n),
  .sel_a     (sel_a),
  .sel_b     (sel_b),
  .burst_cont(burst_cont),
  .wr_n      (wr_n),
  .addr      (addr),
  .dq_oe     (dq_oe),
  .echo_oe   (echo_oe),
  .eff_addr  (eff_addr),
  .step      (step)
);

// File: tb/test_sram_lw_top.sv
module test_sram_lw_top;
  localparam int DATA_W = 36;
  localparam int ADDR_W = 6;
  localparam int LANES  = DATA_W / 9;
  localparam bit POL_A  = 1'b1;
  localparam bit POL_B  = 1'b0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              ce_n = 1'b1, sel_a = POL_A, sel_b = POL_B;
  logic              burst_cont = 1'b0, wr_n = 1'b1;
  logic [LANES-1:0]  lane_wr_n = '1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] dq_i = '0;
  logic [DATA_W-1:0] dq_o;
  logic              dq_oe, echo_oe;

  int checks = 0;
  int fails  = 0;

  sram_lw_top #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .POL_A(POL_A), .POL_B(POL_B)
  ) i_sram_lw_top (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sel_a(sel_a), .sel_b(sel_b),
    .burst_cont(burst_cont), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .echo_oe(echo_oe)
  );

  // Reference model state
  typedef enum {M_BANK, M_IDLE, M_READ, M_WRITE} mop_e;
  logic [DATA_W-1:0] ref_mem [1 << ADDR_W];
  mop_e              m_op = M_IDLE;
  logic [ADDR_W-1:0] m_base = '0;
  logic [1:0]        m_cnt = '0;
  logic [LANES-1:0]  m_lanes_n = '1;
  logic              m_echo = 1'b1;
  logic [DATA_W-1:0] nxt_d = '0;

  function automatic logic [DATA_W-1:0] pat(input int a);
    logic [63:0]  v = (64'(a) + 64'd1) * 64'h9E37_79B9_7F4A_7C15;
    logic [127:0] w = {v, ~v};
    return w[DATA_W-1:0];
  endfunction

  function automatic logic [ADDR_W-1:0] m_addr();
    logic [1:0] lo = m_base[1:0] + m_cnt;
    return {m_base[ADDR_W-1:2], lo};
  endfunction

  task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: drive command (with nxt_d as the late-write data), update model, check.
  // sm: 0 selects valid, 1 sel_a wrong, 2 sel_b wrong.
  task automatic issue(input logic c_n, input logic cont, input logic w_n,
                       input logic [LANES-1:0] ln, input int a, input int sm,
                       input string tag);
    logic en = (sm == 0);
    ce_n = c_n; burst_cont = cont; wr_n = w_n; lane_wr_n = ln;
    addr = ADDR_W'(a); dq_i = nxt_d;
    sel_a = (sm == 1) ? ~POL_A : POL_A;
    sel_b = (sm == 2) ? ~POL_B : POL_B;
    if (m_op == M_WRITE)
      for (int i = 0; i < LANES; i++)
        if (!m_lanes_n[i]) ref_mem[m_addr()][i*9 +: 9] = nxt_d[i*9 +: 9];
    m_echo = (m_op != M_BANK);
    if (!cont) begin
      if (!en) m_op = M_BANK;
      else if (c_n) m_op = M_IDLE;
      else begin
        m_op = w_n ? M_READ : M_WRITE;
        m_base = ADDR_W'(a);
        m_cnt = 2'd0;
      end
    end else if (m_op == M_READ || m_op == M_WRITE) begin
      m_cnt = m_cnt + 2'd1;
    end
    m_lanes_n = ln;
    @(posedge clk);
    @(negedge clk);
    check({tag, " oe"}, 72'(dq_oe), 72'(m_op == M_READ));
    check({tag, " echo"}, 72'(echo_oe), 72'(m_echo));
    if (m_op == M_READ) check({tag, " data"}, 72'(dq_o), 72'(ref_mem[m_addr()]));
  endtask

  task automatic rd(input int a, input string tag);
    issue(1'b0, 1'b0, 1'b1, '1, a, 0, tag);
  endtask
  task automatic wr(input int a, input logic [LANES-1:0] ln, input string tag);
    issue(1'b0, 1'b0, 1'b0, ln, a, 0, tag);
  endtask
  task automatic cont(input logic [LANES-1:0] ln, input string tag);
    issue(1'b0, 1'b1, 1'b0, ln, 0, 0, tag);
  endtask
  task automatic desel(input string tag);
    issue(1'b1, 1'b0, 1'b1, '1, 0, 0, tag);
  endtask

  task automatic t_reset();
    check("R11 oe in reset", 72'(dq_oe), 72'(0));
    check("R11 echo in reset", 72'(echo_oe), 72'(1));
    rst_n = 1'b1;
    desel("R11 first deselect");
    check("R11 oe after reset", 72'(dq_oe), 72'(0));
  endtask

  task automatic t_fill();
    for (int b = 0; b < (1 << ADDR_W) / 4; b++) begin
      wr(b * 4, '0, "R3 fill base");
      nxt_d = pat(b * 4);
      for (int k = 1; k < 4; k++) begin
        cont('0, "R6 fill continue");
        nxt_d = pat(b * 4 + k);
      end
    end
    rd(0, "R3 fill read 0");
    check("R3 word 0", 72'(dq_o), 72'(pat(0)));
    rd(63, "R3 fill read 63");
    check("R3 word 63", 72'(dq_o), 72'(pat(63)));
  endtask

  task automatic t_burst_read();
    int seq [4] = '{9, 10, 11, 8};
    rd(9, "R5 burst base");
    check("R5 flow-through oe", 72'(dq_oe), 72'(1));
    check("R5 word 9", 72'(dq_o), 72'(pat(9)));
    for (int k = 1; k < 4; k++) begin
      issue(1'b0, 1'b1, 1'b1, '1, 0, 0, "R6 burst continue");
      check("R6 burst address", 72'(dq_o), 72'(pat(seq[k])));
    end
  endtask

  task automatic t_wrap();
    rd(5, "R7 base");
    for (int k = 0; k < 4; k++) issue(1'b0, 1'b1, 1'b1, '1, 0, 0, "R7 continue");
    check("R7 wrapped to base", 72'(dq_o), 72'(pat(5)));
  endtask

  task automatic t_lanes();
    logic [LANES-1:0]  ln = '1;
    logic [DATA_W-1:0] nv = ~pat(20);
    logic [DATA_W-1:0] ex = pat(20);
    ln[0] = 1'b0;
    ln[2] = 1'b0;
    wr(20, ln, "R3 lane write");
    nxt_d = nv;
    desel("R3 data edge");
    ex[0 +: 9]  = nv[0 +: 9];
    ex[18 +: 9] = nv[18 +: 9];
    rd(20, "R3 lane read");
    check("R3 lane merge", 72'(dq_o), 72'(ex));
  endtask

  task automatic t_abort();
    wr(21, '1, "R4 abort write");
    nxt_d = '1;
    desel("R4 abort data");
    rd(21, "R4 abort read");
    check("R4 aborted word", 72'(dq_o), 72'(pat(21)));
    wr(24, '0, "R4 burst write");
    nxt_d = 36'h1_1111_1111;
    cont('1, "R4 burst abort beat");
    nxt_d = 36'h2_2222_2222;
    cont('0, "R4 burst third beat");
    nxt_d = 36'h3_3333_3333;
    rd(24, "R4 read 24");
    check("R4 beat0 stored", 72'(dq_o), 72'(36'h1_1111_1111));
    rd(25, "R4 read 25");
    check("R4 beat1 aborted", 72'(dq_o), 72'(pat(25)));
    rd(26, "R4 read 26");
    check("R4 beat2 stored", 72'(dq_o), 72'(36'h3_3333_3333));
  endtask

  task automatic t_wr_rd();
    wr(30, '0, "R10 write");
    nxt_d = 36'hA_5A5A_5A5A;
    rd(30, "R10 read on data edge");
    check("R10 fresh data", 72'(dq_o), 72'(36'hA_5A5A_5A5A));
  endtask

  task automatic t_deselect();
    rd(40, "R8 base");
    desel("R2 deselect");
    check("R2 no drive", 72'(dq_oe), 72'(0));
    nxt_d = '0;
    cont('0, "R8 continue write 1");
    cont('0, "R8 continue write 2");
    check("R8 no drive", 72'(dq_oe), 72'(0));
    check("R2 echo kept", 72'(echo_oe), 72'(1));
    rd(40, "R8 read 40");
    check("R8 word 40 intact", 72'(dq_o), 72'(pat(40)));
    rd(41, "R8 read 41");
    check("R8 word 41 intact", 72'(dq_o), 72'(pat(41)));
  endtask

  task automatic t_bank();
    issue(1'b0, 1'b0, 1'b1, '1, 12, 1, "R1 sel_a wrong");
    check("R1 no read", 72'(dq_oe), 72'(0));
    check("R9 echo still on", 72'(echo_oe), 72'(1));
    issue(1'b0, 1'b1, 1'b1, '1, 0, 0, "R9 bank continue");
    check("R9 echo off", 72'(echo_oe), 72'(0));
    check("R8 bank continue quiet", 72'(dq_oe), 72'(0));
    issue(1'b0, 1'b0, 1'b1, '1, 12, 2, "R1 sel_b wrong");
    check("R1 no read b", 72'(dq_oe), 72'(0));
    rd(12, "R9 read after bank");
    check("R9 echo lags", 72'(echo_oe), 72'(0));
    check("R5 read after bank", 72'(dq_o), 72'(pat(12)));
    desel("R9 recover");
    check("R9 echo back", 72'(echo_oe), 72'(1));
  endtask

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    t_fill();
    t_burst_read();
    t_wrap();
    t_lanes();
    t_abort();
    t_wr_rd();
    t_deselect();
    t_bank();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule